// File: doc/BRIEF.md
# Dynamic-Rate Nibble Transmitter with Enable-Paced Forwarded Clock

This block sends 4-bit words to an external receiver together with a forwarded strobe clock, `dclk`. Everything runs on one fast system clock. The strobe is an ordinary registered output, not a clock net. A reloadable down-counter produces a one-cycle pacing tick. A two-phase controller advances only on that tick. In the low phase it holds `dclk` low and, if a word is ready, copies it onto `dataOut`. In the high phase it raises `dclk`, and the receiver samples on that rising edge.

A 4-bit rate select chooses one of sixteen divider values. The divider table is computed from two parameters: D(sel) = MIN_DIV + sel*sel*DIV_STEP. The defaults (4 and 5) give D from 4 to 1129 at a 200 MHz system clock, which is a strobe rate from 25 MHz down to about 89 kHz. The select can change while the transmitter runs. A new value is picked up only when the counter next reloads. Upstream logic watches `txAccept` to present the next word or to drop `txReady`. While no word is offered, `dclk` stays low.

Top module: `nibble_tx`

## Requirements
- R1: While `rst` is high at a clock edge, the block is forced to the low phase. After that edge `dclk`, `dataOut` and `txAccept` are all 0.
- R2: Every half-period of `dclk` during continuous sending lasts D(sel) = MIN_DIV + sel*sel*DIV_STEP system cycles, so a full `dclk` period is 2*D(sel) cycles.
- R3: While `txReady` is low, `dclk` stays 0, `txAccept` stays 0 and `dataOut` keeps its value.
- R4: On a pacing tick in the low phase with `txReady` high, `txData` is copied to `dataOut` and the block enters the high phase.
- R5: `dclk` goes to 1 at the first pacing tick after a word is captured. It returns to 0 at the next tick, and it is 0 in the cycle where `txAccept` is 1.
- R6: `dataOut` changes only on cycles where `dclk` reads 0.
- R7: A change of `rateSel` does not alter the half-period in progress. The new divider governs the half-period that starts after the next counter reload.
- R8: A reset asserted while a word is being sent drives `dclk` low and `txAccept` low one cycle later.
- R9: `txAccept` is a one-cycle pulse, given once per captured word, so the number of accept pulses equals the number of `dclk` rising edges once each word's high phase has begun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the only clock of the block |
| rst | input | 1 | Synchronous active-high reset |
| rateSel | input | RATE_W (4) | Index into the computed divider table |
| txReady | input | 1 | A word is offered on `txData` |
| txData | input | DATA_W (4) | Word to send |
| dclk | output | 1 | Registered forwarded strobe clock |
| dataOut | output | DATA_W (4) | Registered transmitted word |
| txAccept | output | 1 | One-cycle pulse: `txData` was captured |

## Verification
Two events can land in the same cycle: a change of `rateSel` and an active phase of the transmitter. The bench changes the select two cycles into a `dclk` high phase. It then judges the high phase by the old divider and the following low phase by the new one. A second pairing is reset arriving mid-word, which is provoked while `dclk` is high and judged one cycle later. Alongside these, a cycle-level model built from the requirements is compared on every cycle, and a sweep over all sixteen rates compares each measured `dclk` period with 2*D(sel).

// File: rtl/nibble_tx_pkg.sv
package nibble_tx_pkg;

  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } phase_e;

  typedef struct packed {
    logic loadWord;
    logic driveLow;
    logic driveHigh;
  } strobes_t;

endpackage

// File: rtl/nibble_tx_pace.sv
module nibble_tx_pace #(
  parameter int RATE_W   = 4,
  parameter int MIN_DIV  = 4,
  parameter int DIV_STEP = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RATE_W-1:0] rateSel,
  output logic              tick
);

  localparam int NUM_RATES = 1 << RATE_W;
  localparam int MAX_DIV   = MIN_DIV + (NUM_RATES - 1) * (NUM_RATES - 1) * DIV_STEP;
  localparam int DIV_W     = $clog2(MAX_DIV + 1);

  logic [DIV_W-1:0] divTable [NUM_RATES];
  logic [DIV_W-1:0] count;

  // Divider table computed from the rate index, quadratic spacing.
  for (genvar g = 0; g < NUM_RATES; g++) begin : g_div
    assign divTable[g] = DIV_W'(MIN_DIV + g * g * DIV_STEP);
  end

  // New select is sampled only when the counter reloads.
  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      tick  <= 1'b0;
    end else if (count == '0) begin
      tick  <= 1'b1;
      count <= divTable[rateSel] - DIV_W'(1);
    end else begin
      tick  <= 1'b0;
      count <= count - DIV_W'(1);
    end
  end

endmodule

// File: rtl/nibble_tx_ctrl.sv
module nibble_tx_ctrl
  import nibble_tx_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     tick,
  input  logic     txReady,
  output strobes_t strb
);

  phase_e phase, phaseNext;

  always_comb begin
    strb      = '0;
    phaseNext = phase;
    if (tick) begin
      unique case (phase)
        PH_LOW: begin
          strb.driveLow = 1'b1;
          if (txReady) begin
            strb.loadWord = 1'b1;
            phaseNext     = PH_HIGH;
          end
        end
        PH_HIGH: begin
          strb.driveHigh = 1'b1;
          phaseNext      = PH_LOW;
        end
        default: phaseNext = PH_LOW;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_LOW;
    else     phase <= phaseNext;
  end

endmodule

// File: rtl/nibble_tx_data.sv
module nibble_tx_data
  import nibble_tx_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  strobes_t          strb,
  input  logic [DATA_W-1:0] txData,
  output logic              dclk,
  output logic [DATA_W-1:0] dataOut,
  output logic              txAccept
);

  // All outputs straight from flops.
  always_ff @(posedge clk) begin
    if (rst) begin
      dclk     <= 1'b0;
      dataOut  <= '0;
      txAccept <= 1'b0;
    end else begin
      txAccept <= strb.loadWord;
      if (strb.loadWord)  dataOut <= txData;
      if (strb.driveLow)  dclk    <= 1'b0;
      else if (strb.driveHigh) dclk <= 1'b1;
    end
  end

endmodule

// File: rtl/nibble_tx.sv
module nibble_tx
  import nibble_tx_pkg::*;
#(
  parameter int DATA_W   = 4,
  parameter int RATE_W   = 4,
  parameter int MIN_DIV  = 4,
  parameter int DIV_STEP = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RATE_W-1:0] rateSel,
  input  logic              txReady,
  input  logic [DATA_W-1:0] txData,
  output logic              dclk,
  output logic [DATA_W-1:0] dataOut,
  output logic              txAccept
);

  logic     tick;
  strobes_t strb;

  nibble_tx_pace #(
    .RATE_W  (RATE_W),
    .MIN_DIV (MIN_DIV),
    .DIV_STEP(DIV_STEP)
  ) pace_i (
    .clk    (clk),
    .rst    (rst),
    .rateSel(rateSel),
    .tick   (tick)
  );

  nibble_tx_ctrl ctrl_i (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .txReady(txReady),
    .strb   (strb)
  );

  nibble_tx_data #(
    .DATA_W(DATA_W)
  ) data_i (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .txData  (txData),
    .dclk    (dclk),
    .dataOut (dataOut),
    .txAccept(txAccept)
  );

endmodule

// File: rtl/nibble_tx_checker.sv
module nibble_tx_checker #(
  parameter int DATA_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              txReady,
  input logic              dclk,
  input logic [DATA_W-1:0] dataOut,
  input logic              txAccept
);

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!dclk && !txAccept));

  a_r3_no_accept_idle: assert property (@(posedge clk) disable iff (rst)
    (!txReady && !dclk) |=> !txAccept);

  a_r5_low_at_accept: assert property (@(posedge clk) disable iff (rst)
    txAccept |-> !dclk);

  a_r6_data_moves_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(dataOut) |-> !dclk);

  a_r9_accept_single: assert property (@(posedge clk) disable iff (rst)
    txAccept |=> !txAccept);

endmodule

bind nibble_tx nibble_tx_checker #(.DATA_W(DATA_W)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .txReady (txReady),
  .dclk    (dclk),
  .dataOut (dataOut),
  .txAccept(txAccept)
);

// File: tb/nibble_tx_tb_top.sv
module nibble_tx_tb_top;

  localparam int MIN_D = 2;
  localparam int STEP  = 1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] rateSel = 4'd0;
  logic       txReady = 1'b0;
  logic [3:0] txData = 4'd0;
  wire        dclk;
  wire  [3:0] dataOut;
  wire        txAccept;

  int  errs = 0;
  int  checks = 0;
  bit  done = 1'b0;

  nibble_tx #(.DATA_W(4), .RATE_W(4), .MIN_DIV(MIN_D), .DIV_STEP(STEP)) dut_i (
    .clk(clk), .rst(rst), .rateSel(rateSel), .txReady(txReady), .txData(txData),
    .dclk(dclk), .dataOut(dataOut), .txAccept(txAccept)
  );

  always #10 clk = ~clk;

  function automatic int divOf(int s);
    return MIN_D + s * s * STEP;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Cycle model built from the requirements.
  int       mCnt = 0;
  bit       mEn = 0, mPh = 0, mDclk = 0, mAcc = 0;
  logic [3:0] mData = 4'd0;

  always @(posedge clk) begin
    if (rst) begin
      mCnt = 0; mEn = 0; mPh = 0; mDclk = 0; mAcc = 0; mData = 4'd0;
    end else begin
      mAcc = 0;
      if (mEn) begin
        if (!mPh) begin
          mDclk = 0;
          if (txReady) begin mData = txData; mPh = 1; mAcc = 1; end
        end else begin
          mDclk = 1; mPh = 0;
        end
      end
      if (mCnt == 0) begin mEn = 1; mCnt = divOf(int'(rateSel)) - 1; end
      else begin mEn = 0; mCnt = mCnt - 1; end
    end
  end

  // Per-cycle comparison and edge bookkeeping.
  int   cyc = 0, riseCount = 0, accCount = 0, lastRise = 0, prevRise = 0, lastFall = 0;
  logic prevDclk = 1'b0;
  logic [3:0] prevData = 4'd0;

  always @(negedge clk) begin
    cyc++;
    if (!done) begin
      check(dclk === mDclk, "R5 dclk", int'(dclk), int'(mDclk));
      check(dataOut === mData, "R4 dataOut", int'(dataOut), int'(mData));
      check(txAccept === mAcc, "R9 txAccept", int'(txAccept), int'(mAcc));
      if (dataOut !== prevData) check(!dclk, "R6 data change while dclk high", int'(dclk), 0);
    end
    if (dclk && !prevDclk) begin riseCount++; prevRise = lastRise; lastRise = cyc; end
    if (!dclk && prevDclk) lastFall = cyc;
    if (txAccept) accCount++;
    prevDclk = dclk;
    prevData = dataOut;
  end

  // Upstream source: next word on every accept.
  always @(negedge clk) if (txAccept) txData <= txData + 4'd3;

  task automatic waitRises(int n);
    int target = riseCount + n;
    while (riseCount < target) @(negedge clk);
  endtask

  task automatic waitFall();
    int last = lastFall;
    while (lastFall == last) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(dclk == 1'b0, "R1 dclk after reset", int'(dclk), 0);
    check(dataOut == 4'd0, "R1 dataOut after reset", int'(dataOut), 0);
    check(txAccept == 1'b0, "R1 txAccept after reset", int'(txAccept), 0);
    rst = 1'b0;

    // R3: idle over several rates
    foreach (dut_i.rateSel[k]) ;
    for (int s = 0; s < 16; s += 5) begin
      rateSel = 4'(s);
      repeat (300) @(negedge clk);
    end
    check(riseCount == 0, "R3 no dclk edge while idle", riseCount, 0);
    check(accCount == 0, "R3 no accept while idle", accCount, 0);
    check(dataOut == 4'd0, "R3 dataOut held while idle", int'(dataOut), 0);

    // R2: sweep every rate
    txReady = 1'b1;
    for (int s = 0; s < 16; s++) begin
      rateSel = 4'(s);
      waitRises(2);
      waitRises(1);
      check(lastRise - prevRise == 2 * divOf(s), "R2 dclk period", lastRise - prevRise, 2 * divOf(s));
    end

    // R9: accepts match rising edges
    waitRises(1);
    check(accCount == riseCount, "R9 accepts equal rises", accCount, riseCount);

    // R7: select change inside a high phase
    rateSel = 4'd3;
    waitRises(3);
    repeat (2) @(negedge clk);
    rateSel = 4'd0;
    waitFall();
    check(lastFall - lastRise == divOf(3), "R7 high phase keeps old divider", lastFall - lastRise, divOf(3));
    waitRises(1);
    check(lastRise - lastFall == divOf(0), "R7 low phase uses new divider", lastRise - lastFall, divOf(0));

    // R8: reset mid-word
    rateSel = 4'd2;
    waitRises(2);
    rst = 1'b1;
    @(negedge clk);
    check(dclk == 1'b0, "R8 dclk low after reset", int'(dclk), 0);
    check(txAccept == 1'b0, "R8 accept low after reset", int'(txAccept), 0);
    check(dataOut == 4'd0, "R8 dataOut cleared", int'(dataOut), 0);
    rst = 1'b0;
    repeat (60) @(negedge clk);
    txReady = 1'b0;
    repeat (60) @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1'b1;
      errs++;
      checks++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", cyc, 200000);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule